// File: doc/BRIEF.md
# Configurable Logic Tile with Neighbour Routing

This block is one tile of an island-style reconfigurable array. It holds a K-input lookup table and a set of 4-to-1 routing multiplexers. The tile connects only to its four neighbours. Each side carries an N-bit channel in and an N-bit channel out. One multiplexer picks the channel signal for each LUT input. One multiplexer per outgoing channel bit passes either the LUT result or a signal from one of the other three sides.

The tile's behaviour comes from a configuration store that is loaded serially while `cfg_en` is high. The store holds the LUT contents and the multiplexer select pairs. Each clock shifts in one bit, taken from a two-bit configuration word by a half-select input. The bit leaving the far end appears on `cfg_out`, so tiles can be chained into one long configuration path.

When `cfg_en` is low, the LUT and the routing are purely combinational from the neighbour inputs. While configuration is loading, the outputs freeze.

Top module: `logic_tile`

## Requirements
- R1: After reset every configuration bit is 0. The tile then drives `f`=0, `f_n`=1, every directional output 0 and `cfg_out`=0.
- R2: While `cfg_en` is high, one bit is shifted in per clock. The bit is `cfg_in[1]` when `cfg_sel`=1 and `cfg_in[0]` when `cfg_sel`=0. The first bit shifted in ends up at stream position 0 once all CFG_LEN bits have been loaded.
- R3: Stream layout for K=3, N=1 (CFG_LEN=22):
  - positions 0..7 hold LUT entries 0..7;
  - positions 8+2j (select LSB) and 9+2j hold the select for LUT input j;
  - positions 14..21 hold the output-mux selects, LSB first, for north, east, south and west in that order.
- R4: `cfg_out` presents the bit at stream position 0. During a reload it emits the old stream, position 0 first, one bit per clock.
- R5: A LUT input select code of 0/1/2/3 picks the north/east/south/west input, using channel bit j mod N.
- R6: LUT input j drives address bit j. The address selects exactly one entry (one-hot decode). `f` is that entry and `f_n` is its complement.
- R7: An output-mux code of 0 passes `f`. Codes 1, 2 and 3 pass the inputs of the other three sides, taken in north, east, south, west order with the output's own side skipped. For example, the east output uses codes 1/2/3 for north/south/west.
- R8: While `cfg_en` is high, `f`, `f_n` and all directional outputs hold the values they had at the last clock edge with `cfg_en` low.
- R9: While `cfg_en` is low, the configuration store does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | High: shift configuration and freeze outputs |
| cfg_sel | input | 1 | Picks which bit of `cfg_in` is shifted (1 = upper) |
| cfg_in | input | 2 | Configuration word |
| cfg_out | output | 1 | Configuration chain output |
| n_in | input | N | Channel from the north neighbour |
| e_in | input | N | Channel from the east neighbour |
| s_in | input | N | Channel from the south neighbour |
| w_in | input | N | Channel from the west neighbour |
| n_out | output | N | Channel to the north neighbour |
| e_out | output | N | Channel to the east neighbour |
| s_out | output | N | Channel to the south neighbour |
| w_out | output | N | Channel to the west neighbour |
| f | output | 1 | LUT result |
| f_n | output | 1 | Complement of the LUT result |

## Verification
The bench builds the tile with K=3 and N=1. This gives a 22-bit stream in which every select pair and all eight LUT entries can be set one by one. It also lets all 16 patterns of the four side inputs be applied per configuration. Two configurations are used:
- one routes all three LUT inputs from different sides;
- one feeds the same side into two LUT inputs and sends a side signal straight through.

Together they reach every output-mux code and every LUT-input code except east-less repeats. Reloading the second configuration exposes the first one on `cfg_out`, with the half-select alternating on every bit.

// File: rtl/tile_pkg.sv
package tile_pkg;
  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  function automatic int stream_len(input int k, input int n);
    return (1 << k) + 2 * k + 8 * n;
  endfunction
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int LEN = 22
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           sel,
  input  logic [1:0]     din,
  output logic [LEN-1:0] q,
  output logic           dout
);
  logic           bit_in;
  logic [LEN-1:0] q_nxt;

  always_comb begin
    bit_in = sel ? din[1] : din[0];
    q_nxt  = q;
    if (en) q_nxt = {bit_in, q[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign dout = q[0];

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

  // R2
  cfg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> q[LEN-1] == $past(sel ? din[1] : din[0]));
endmodule

// File: rtl/route_mux4.sv
module route_mux4 #(
  parameter int W = 1
) (
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  input  logic [W-1:0] d2,
  input  logic [W-1:0] d3,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = d0;
      2'd1:    y = d1;
      2'd2:    y = d2;
      default: y = d3;
    endcase
  end
endmodule

// File: rtl/lut_core.sv
module lut_core #(
  parameter int K = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [K-1:0]       addr,
  input  logic [(1<<K)-1:0]  entries,
  output logic               f,
  output logic               f_n
);
  localparam int DEPTH = 1 << K;

  logic [DEPTH-1:0] dec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign dec[i] = (addr == K'(i));
  end

  assign f   = |(dec & entries);
  assign f_n = ~f;

  // R6
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec) == 1);
endmodule

// File: rtl/logic_tile.sv
module logic_tile #(
  parameter int K = 3,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_sel,
  input  logic [1:0]   cfg_in,
  output logic         cfg_out,
  input  logic [N-1:0] n_in,
  input  logic [N-1:0] e_in,
  input  logic [N-1:0] s_in,
  input  logic [N-1:0] w_in,
  output logic [N-1:0] n_out,
  output logic [N-1:0] e_out,
  output logic [N-1:0] s_out,
  output logic [N-1:0] w_out,
  output logic         f,
  output logic         f_n
);
  import tile_pkg::*;

  localparam int DEPTH     = 1 << K;
  localparam int LSEL_BASE = DEPTH;
  localparam int OSEL_BASE = DEPTH + 2 * K;
  localparam int CFG_LEN   = stream_len(K, N);
  localparam int OUT_W     = 4 * N + 1;

  logic [1:0]         rst_sync;
  logic               rst_i_n;
  logic [CFG_LEN-1:0] cfg_q;
  logic [K-1:0]       lut_addr;
  logic               f_live;
  logic               f_n_live;
  logic [4*N-1:0]     side_in;
  logic [4*N-1:0]     side_live;
  logic [OUT_W-1:0]   live_vec;
  logic [OUT_W-1:0]   hold_q;
  logic [OUT_W-1:0]   hold_d;
  logic [OUT_W-1:0]   out_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  cfg_chain #(.LEN(CFG_LEN)) i_chain (
    .clk  (clk),
    .rst_n(rst_i_n),
    .en   (cfg_en),
    .sel  (cfg_sel),
    .din  (cfg_in),
    .q    (cfg_q),
    .dout (cfg_out)
  );

  assign side_in = {w_in, s_in, e_in, n_in};

  for (genvar j = 0; j < K; j++) begin : g_lsel
    localparam int CH = j % N;
    route_mux4 #(.W(1)) i_lmux (
      .d0 (side_in[int'(SIDE_N)*N + CH]),
      .d1 (side_in[int'(SIDE_E)*N + CH]),
      .d2 (side_in[int'(SIDE_S)*N + CH]),
      .d3 (side_in[int'(SIDE_W)*N + CH]),
      .sel(cfg_q[LSEL_BASE + 2*j +: 2]),
      .y  (lut_addr[j])
    );
  end

  lut_core #(.K(K)) i_lut (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .addr   (lut_addr),
    .entries(cfg_q[DEPTH-1:0]),
    .f      (f_live),
    .f_n    (f_n_live)
  );

  for (genvar d = 0; d < 4; d++) begin : g_side
    localparam int O1 = (d == 0) ? 1 : 0;
    localparam int O2 = (d <= 1) ? 2 : 1;
    localparam int O3 = (d <= 2) ? 3 : 2;
    for (genvar c = 0; c < N; c++) begin : g_ch
      route_mux4 #(.W(1)) i_omux (
        .d0 (f_live),
        .d1 (side_in[O1*N + c]),
        .d2 (side_in[O2*N + c]),
        .d3 (side_in[O3*N + c]),
        .sel(cfg_q[OSEL_BASE + 2*(d*N + c) +: 2]),
        .y  (side_live[d*N + c])
      );
    end
  end

  assign live_vec = {f_live, side_live};

  // freeze register: next-state and storage kept apart
  always_comb begin
    hold_d = live_vec;
    if (cfg_en) hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) hold_q <= '0;
    else          hold_q <= hold_d;
  end

  assign out_vec = cfg_en ? hold_q : live_vec;
  assign n_out   = out_vec[int'(SIDE_N)*N +: N];
  assign e_out   = out_vec[int'(SIDE_E)*N +: N];
  assign s_out   = out_vec[int'(SIDE_S)*N +: N];
  assign w_out   = out_vec[int'(SIDE_W)*N +: N];
  assign f       = out_vec[OUT_W-1];
  assign f_n     = cfg_en ? ~hold_q[OUT_W-1] : f_n_live;

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_en && $past(cfg_en)) |-> $stable({n_out, e_out, s_out, w_out, f}));

  // R7
  north_f_pass_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!cfg_en && cfg_q[OSEL_BASE +: 2] == 2'd0) |-> n_out[0] == f_live);

  // R6
  compl_pair_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    f_n != f);
endmodule

// File: tb/test_logic_tile.sv
module test_logic_tile;
  localparam int K  = 3;
  localparam int N  = 1;
  localparam int CL = 22;

  typedef struct {
    string    req;
    logic [6:0] exp;
    logic [6:0] mask;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_en;
  logic       cfg_sel;
  logic [1:0] cfg_in;
  logic       cfg_out;
  logic [N-1:0] n_in, e_in, s_in, w_in;
  logic [N-1:0] n_out, e_out, s_out, w_out;
  logic       f, f_n;

  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  always #2 clk = ~clk;

  logic_tile #(.K(K), .N(N)) i_logic_tile (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
    .cfg_in(cfg_in), .cfg_out(cfg_out),
    .n_in(n_in), .e_in(e_in), .s_in(s_in), .w_in(w_in),
    .n_out(n_out), .e_out(e_out), .s_out(s_out), .w_out(w_out),
    .f(f), .f_n(f_n)
  );

  // stream: lut[7:0], lut input selects at 8..13, output selects N,E,S,W at 14..21 (R3)
  function automatic logic [CL-1:0] mk_cfg(input logic [7:0] lut,
      input logic [1:0] l0, input logic [1:0] l1, input logic [1:0] l2,
      input logic [1:0] on, input logic [1:0] oe, input logic [1:0] os,
      input logic [1:0] ow);
    return {ow, os, oe, on, l2, l1, l0, lut};
  endfunction

  // expected {f_n, f, w, s, e, n}; ch bit0 N, 1 E, 2 S, 3 W
  function automatic logic [5:0] model(input logic [CL-1:0] c, input logic [3:0] ch);
    logic [2:0] a;
    logic       fv;
    logic [3:0] o;
    for (int j = 0; j < K; j++) a[j] = ch[c[8+2*j +: 2]];
    fv = c[a];
    for (int d = 0; d < 4; d++) begin
      logic [1:0] code;
      int others[3];
      int k;
      code = c[14+2*d +: 2];
      k = 0;
      for (int s = 0; s < 4; s++) if (s != d) begin others[k] = s; k++; end
      o[d] = (code == 2'd0) ? fv : ch[others[code-1]];
    end
    return {~fv, fv, o[3], o[2], o[1], o[0]};
  endfunction

  task automatic push(input string req, input logic [6:0] exp, input logic [6:0] mask);
    item_t it;
    it.req = req; it.exp = exp; it.mask = mask;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load_cfg(input logic [CL-1:0] c, input bit chk, input logic [CL-1:0] prev);
    cfg_en = 1'b1;
    for (int i = 0; i < CL; i++) begin
      cfg_sel = i[0];
      cfg_in  = i[0] ? {c[i], ~c[i]} : {~c[i], c[i]};
      if (chk) push("R4 chain output", {prev[i], 6'b0}, 7'b1000000);
      step();
    end
    cfg_en = 1'b0;
  endtask

  task automatic apply(input string req, input logic [CL-1:0] c, input logic [3:0] ch);
    {w_in, s_in, e_in, n_in} = ch;
    push(req, {1'b0, model(c, ch)}, 7'b0111111);
    step();
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [6:0] obs;
        it  = q.pop_front();
        obs = {cfg_out, f_n, f, w_out, s_out, e_out, n_out};
        checks++;
        if ((obs & it.mask) !== (it.exp & it.mask)) begin
          fails++;
          $display("FAIL %s: actual %b expected %b (mask %b)", it.req, obs, it.exp, it.mask);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CL-1:0] c1, c2;
    logic [3:0]    last;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_sel = 1'b0; cfg_in = 2'b00;
    n_in = '0; e_in = '0; s_in = '0; w_in = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    push("R1 reset state", 7'b0100000, 7'b1111111);
    step();
    {w_in, s_in, e_in, n_in} = 4'b1111;
    push("R1 reset state, inputs high", 7'b0100000, 7'b1111111);
    step();

    // xor3 of N,E,S; N<-F, E<-W, S<-N, W<-E
    c1 = mk_cfg(8'h96, 2'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd1, 2'd2);
    load_cfg(c1, 1'b0, '0);
    for (int p = 0; p < 16; p++) apply("R2/R3/R5/R6/R7 config A", c1, 4'(p));

    // majority; inputs W,W,N; N<-S, E<-N, S<-W, W<-F
    c2 = mk_cfg(8'hE8, 2'd3, 2'd3, 2'd0, 2'd2, 2'd1, 2'd3, 2'd0);
    load_cfg(c2, 1'b1, c1);
    for (int p = 0; p < 16; p++) apply("R2/R3/R5/R6/R7 config B", c2, 4'(15 - p));

    // R9: idle cycles with noise on the config word, no shift
    cfg_in = 2'b11; cfg_sel = 1'b1;
    repeat (4) step();
    apply("R9 config held", c2, 4'b1010);
    apply("R9 config held", c2, 4'b0101);

    // R8 freeze: outputs keep values from pattern 'last'
    last = 4'b0110;
    apply("R8 pre-freeze", c2, last);
    cfg_en = 1'b1;
    for (int p = 0; p < 3; p++) begin
      {w_in, s_in, e_in, n_in} = 4'(p * 5 + 1);
      push("R8 freeze hold", {1'b0, model(c2, last)}, 7'b0111111);
      step();
    end
    cfg_en = 1'b0;
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule